// File: doc/BRIEF.md
# Memory Configuration Command Bridge

This block sits between a Wishbone slave port and the command input of a low-power DDR memory controller. The port carries only configuration and power-control traffic. Every mapped register address is a single set bit. A write to such an address becomes one controller command: mode register load, extended mode register load, power-down entry or exit, deep power-down entry or exit, self-refresh entry or exit, or status register read. For the two mode register loads, the relevant write-data bits are packed into the register field layout.

A forwarded command is offered on a request/accept handshake. The bus cycle that caused it is acknowledged one clock after the controller accepts it. The bridge tracks which low-power state the memory has been placed in. It refuses an exit that has no matching entry, and it refuses an entry while another low-power state is active. Refused, unmapped and read cycles end in an error termination. A master that abandons a cycle leaves its command pending. Any cycle that arrives while that command is still pending ends in a retry termination.

Top module: `memcfg_wb_bridge`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `wb_ack`, `wb_err`, `wb_rty` and `cmd_req` are low.
- R2: A write to address 0x001 issues command code 1. `cmd_arg` is the write data bits [6:0]: burst length in [2:0], burst type in bit 3 and read latency in [6:4]. Data bits above 6 are ignored and the upper argument bits are zero.
- R3: A write to address 0x002 issues command code 2. `cmd_arg` is the write data bits [7:0]: partial-array selection in [2:0], temperature-compensation setting in [4:3] and output drive strength in [7:5]. Data bits above 7 are ignored and the upper argument bits are zero.
- R4: Writes to the addresses in the table below issue the listed command codes with `cmd_arg` equal to zero, whatever the write data.

  | Address | Command | Code |
  |---|---|---|
  | 0x004 | power-down entry | 3 |
  | 0x008 | power-down exit | 4 |
  | 0x010 | deep power-down entry | 5 |
  | 0x020 | deep power-down exit | 6 |
  | 0x040 | self-refresh entry | 7 |
  | 0x080 | self-refresh exit | 8 |
  | 0x100 | status read | 9 |

- R5: Once raised, `cmd_req` stays high with `cmd_code` and `cmd_arg` unchanged until `cmd_accept` is sampled high. `wb_ack` pulses in the clock after that accept edge, provided the originating cycle is still open.
- R6: An exit (code 4, 6 or 8) is refused with `wb_err` unless the matching entry was the last low-power command issued. An entry (code 3, 5 or 7) is refused with `wb_err` while any low-power state is active. A refused write issues no command.
- R7: A write to any address that is not one of the nine values above (including zero, and values with several bits set), or any read cycle, terminates with `wb_err` and issues no command.
- R8: A cycle that arrives while a forwarded command is still unaccepted terminates with `wb_rty` and issues no command.
- R9: `wb_ack`, `wb_err` and `wb_rty` are one-cycle pulses, and at most one of them is high in any cycle. No new cycle is decoded in the cycle in which a response is shown.
- R10: If the master drops `wb_cyc` before its command is accepted, the later accept produces no `wb_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wb_cyc | input | 1 | Bus cycle in progress |
| wb_stb | input | 1 | Strobe for this slave |
| wb_we | input | 1 | Write (1) or read (0) cycle |
| wb_adr | input | ADR_W | One-hot register address |
| wb_dat | input | DAT_W | Write data |
| wb_ack | output | 1 | Normal termination pulse |
| wb_err | output | 1 | Abnormal termination pulse |
| wb_rty | output | 1 | Retry termination pulse |
| cmd_req | output | 1 | Command offered to the controller |
| cmd_code | output | 4 | Command code, per R2 to R4 |
| cmd_arg | output | ARG_W | Packed mode register argument |
| cmd_accept | input | 1 | Controller takes the offered command |

## Verification
The bench builds the block with its defaults: ADR_W of 12, DAT_W of 32 and ARG_W of 12. Because the address is 12 bits wide, three bits lie above the nine mapped ones, so a single set bit at 0x200 can exercise the unmapped one-hot case. The 32-bit data and 12-bit argument let the bench drive ones into every data bit beyond the packed fields and confirm that the argument's upper bits stay zero. With accept delays of zero to two cycles, the request hold, the abandoned-cycle retry and the silent late accept all fall within reach.

// File: rtl/memcfg_pkg.sv
package memcfg_pkg;

    // Controller command codes presented on cmd_code.
    typedef enum logic [3:0] {
        CFG_NONE     = 4'd0,
        CFG_MRS      = 4'd1,
        CFG_EMRS     = 4'd2,
        CFG_PD_IN    = 4'd3,
        CFG_PD_OUT   = 4'd4,
        CFG_DPD_IN   = 4'd5,
        CFG_DPD_OUT  = 4'd6,
        CFG_SR_IN    = 4'd7,
        CFG_SR_OUT   = 4'd8,
        CFG_STATUS   = 4'd9
    } cfg_cmd_e;

    // Number of one-hot addresses that carry a command (bit i -> code i+1).
    localparam int unsigned CFG_MAPPED_N = 9;

    // Mode register layout (low bits of the argument).
    typedef struct packed {
        logic [2:0] rd_lat;
        logic       wrap_il;
        logic [2:0] burst_len;
    } mr_fields_t;

    // Extended mode register layout (low bits of the argument).
    typedef struct packed {
        logic [2:0] drive;
        logic [1:0] temp_comp;
        logic [2:0] array_part;
    } emr_fields_t;

    typedef enum logic [1:0] {
        PWR_AWAKE = 2'd0,
        PWR_PD    = 2'd1,
        PWR_DPD   = 2'd2,
        PWR_SR    = 2'd3
    } pwr_state_e;

endpackage

// File: rtl/memcfg_addr_decode.sv
module memcfg_addr_decode
    import memcfg_pkg::*;
#(
    parameter int unsigned ADR_W = 12,
    parameter int unsigned DAT_W = 32,
    parameter int unsigned ARG_W = 12
) (
    input  logic [ADR_W-1:0] adr,
    input  logic [DAT_W-1:0] dat,
    output cfg_cmd_e         kind,
    output logic [ARG_W-1:0] arg
);
    localparam int unsigned ONES_W = $clog2(ADR_W + 1);
    localparam int unsigned IDX_W  = $clog2(ADR_W);
    localparam int unsigned MR_W   = $bits(mr_fields_t);
    localparam int unsigned EMR_W  = $bits(emr_fields_t);

    logic [ONES_W-1:0] ones_d;
    logic [IDX_W-1:0]  idx_d;
    mr_fields_t        mr_d;
    emr_fields_t       emr_d;

    // Count set bits and remember the position of the highest one.
    always_comb begin
        ones_d = '0;
        idx_d  = '0;
        for (int i = 0; i < int'(ADR_W); i++) begin
            if (adr[i]) begin
                ones_d = ones_d + ONES_W'(1);
                idx_d  = IDX_W'(i);
            end
        end
    end

    // Field packing: only the bits that belong to a field survive.
    always_comb begin
        mr_d  = mr_fields_t'(dat[MR_W-1:0]);
        emr_d = emr_fields_t'(dat[EMR_W-1:0]);
    end

    always_comb begin
        kind = CFG_NONE;
        arg  = '0;
        if (ones_d == ONES_W'(1) && int'(idx_d) < int'(CFG_MAPPED_N)) begin
            kind = cfg_cmd_e'(4'(idx_d) + 4'd1);
        end
        case (kind)
            CFG_MRS:  arg = ARG_W'(mr_d);
            CFG_EMRS: arg = ARG_W'(emr_d);
            default:  arg = '0;
        endcase
    end

endmodule

// File: rtl/memcfg_pwr_track.sv
module memcfg_pwr_track
    import memcfg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  cfg_cmd_e kind,
    input  logic     issue,
    output logic     legal
);
    pwr_state_e state_d, state_q;

    always_comb begin
        state_d = state_q;
        legal   = 1'b1;
        case (kind)
            CFG_PD_IN, CFG_DPD_IN, CFG_SR_IN: legal = (state_q == PWR_AWAKE);
            CFG_PD_OUT:  legal = (state_q == PWR_PD);
            CFG_DPD_OUT: legal = (state_q == PWR_DPD);
            CFG_SR_OUT:  legal = (state_q == PWR_SR);
            default:     legal = 1'b1;
        endcase
        if (issue) begin
            case (kind)
                CFG_PD_IN:  state_d = PWR_PD;
                CFG_DPD_IN: state_d = PWR_DPD;
                CFG_SR_IN:  state_d = PWR_SR;
                CFG_PD_OUT, CFG_DPD_OUT, CFG_SR_OUT: state_d = PWR_AWAKE;
                default:    state_d = state_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PWR_AWAKE;
        else        state_q <= state_d;
    end

    // R6: a deep power-down is left only toward the awake state.
    a_r6_dpd_leaves_awake: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PWR_DPD) |=> (state_q == PWR_DPD || state_q == PWR_AWAKE));

    // R6: any low-power state is entered only from the awake state.
    a_r6_entry_from_awake: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PWR_AWAKE && $changed(state_q)) |-> ($past(state_q) == PWR_AWAKE));

endmodule

// File: rtl/memcfg_wb_bridge.sv
module memcfg_wb_bridge
    import memcfg_pkg::*;
#(
    parameter int unsigned ADR_W = 12,
    parameter int unsigned DAT_W = 32,
    parameter int unsigned ARG_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wb_cyc,
    input  logic             wb_stb,
    input  logic             wb_we,
    input  logic [ADR_W-1:0] wb_adr,
    input  logic [DAT_W-1:0] wb_dat,
    output logic             wb_ack,
    output logic             wb_err,
    output logic             wb_rty,
    output logic             cmd_req,
    output logic [3:0]       cmd_code,
    output logic [ARG_W-1:0] cmd_arg,
    input  logic             cmd_accept
);
    typedef struct packed {
        logic             req;
        cfg_cmd_e         code;
        logic [ARG_W-1:0] arg;
        logic             owner;
        logic             ack;
        logic             err;
        logic             rty;
    } bridge_regs_t;

    bridge_regs_t     r_d, r_q;
    cfg_cmd_e         dec_kind;
    logic [ARG_W-1:0] dec_arg;
    logic             pwr_legal;
    logic             issue_d;

    memcfg_addr_decode #(
        .ADR_W (ADR_W),
        .DAT_W (DAT_W),
        .ARG_W (ARG_W)
    ) decode_i (
        .adr  (wb_adr),
        .dat  (wb_dat),
        .kind (dec_kind),
        .arg  (dec_arg)
    );

    memcfg_pwr_track pwr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .kind  (dec_kind),
        .issue (issue_d),
        .legal (pwr_legal)
    );

    always_comb begin
        logic bus_on;
        logic resp_shown;
        r_d        = r_q;
        r_d.ack    = 1'b0;
        r_d.err    = 1'b0;
        r_d.rty    = 1'b0;
        issue_d    = 1'b0;
        bus_on     = wb_cyc & wb_stb;
        resp_shown = r_q.ack | r_q.err | r_q.rty;

        // Hand-off of the pending command.
        if (r_q.req && cmd_accept) begin
            r_d.req   = 1'b0;
            r_d.owner = 1'b0;
            if (r_q.owner && bus_on) r_d.ack = 1'b1;
        end else if (r_q.owner && !wb_cyc) begin
            r_d.owner = 1'b0;   // master walked away; command stays pending
        end

        // Decode of a fresh cycle.
        if (!r_q.owner && bus_on && !resp_shown) begin
            if (r_q.req) begin
                r_d.rty = 1'b1;
            end else if (!wb_we || dec_kind == CFG_NONE || !pwr_legal) begin
                r_d.err = 1'b1;
            end else begin
                r_d.req   = 1'b1;
                r_d.code  = dec_kind;
                r_d.arg   = dec_arg;
                r_d.owner = 1'b1;
                issue_d   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{req: 1'b0, code: CFG_NONE, arg: '0, owner: 1'b0,
                     ack: 1'b0, err: 1'b0, rty: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign wb_ack   = r_q.ack;
    assign wb_err   = r_q.err;
    assign wb_rty   = r_q.rty;
    assign cmd_req  = r_q.req;
    assign cmd_code = r_q.code;
    assign cmd_arg  = r_q.arg;

    // R9: at most one termination per cycle.
    a_r9_one_resp: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wb_ack, wb_err, wb_rty}));

    // R9: every termination lasts exactly one cycle.
    a_r9_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_ack || wb_err || wb_rty) |=> !(wb_ack || wb_err || wb_rty));

    // R5: an offered command is held unchanged until taken.
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && !cmd_accept) |=> (cmd_req && $stable(cmd_code) && $stable(cmd_arg)));

    // R5: acknowledge only right after an accept.
    a_r5_ack_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        wb_ack |-> $past(cmd_req && cmd_accept));

    // R7: an error termination never comes with a new command.
    a_r7_err_no_issue: assert property (@(posedge clk) disable iff (!rst_n)
        wb_err |-> !$rose(cmd_req));

    // R8: a retry is only given while a command was outstanding.
    a_r8_rty_pending: assert property (@(posedge clk) disable iff (!rst_n)
        wb_rty |-> $past(cmd_req));

endmodule

// File: tb/memcfg_wb_bridge_tb_top.sv
module memcfg_wb_bridge_tb_top;

    localparam int unsigned ADR_W = 12;
    localparam int unsigned DAT_W = 32;
    localparam int unsigned ARG_W = 12;

    // resp: 1 = ack, 2 = err, 3 = rty
    typedef struct packed {
        logic [11:0] adr;
        logic [31:0] dat;
        logic [1:0]  resp;
        logic [3:0]  code;
        logic [11:0] arg;
        logic [3:0]  tag;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{12'h001, 32'hFFFF_FF32, 2'd1, 4'd1, 12'h032, 4'd2},
        '{12'h002, 32'hABCD_E1F5, 2'd1, 4'd2, 12'h0F5, 4'd3},
        '{12'h100, 32'hFFFF_FFFF, 2'd1, 4'd9, 12'h000, 4'd4},
        '{12'h008, 32'h0000_0000, 2'd2, 4'd0, 12'h000, 4'd6},
        '{12'h004, 32'h1234_5678, 2'd1, 4'd3, 12'h000, 4'd4},
        '{12'h040, 32'h0000_0000, 2'd2, 4'd0, 12'h000, 4'd6},
        '{12'h008, 32'hFFFF_0000, 2'd1, 4'd4, 12'h000, 4'd4},
        '{12'h020, 32'h0000_0000, 2'd2, 4'd0, 12'h000, 4'd6},
        '{12'h010, 32'h0000_00FF, 2'd1, 4'd5, 12'h000, 4'd4},
        '{12'h020, 32'h0000_0000, 2'd1, 4'd6, 12'h000, 4'd4},
        '{12'h080, 32'h0000_0000, 2'd2, 4'd0, 12'h000, 4'd6},
        '{12'h040, 32'h8000_0001, 2'd1, 4'd7, 12'h000, 4'd4},
        '{12'h080, 32'h0000_0000, 2'd1, 4'd8, 12'h000, 4'd4},
        '{12'h000, 32'h0000_0001, 2'd2, 4'd0, 12'h000, 4'd7},
        '{12'h003, 32'h0000_0001, 2'd2, 4'd0, 12'h000, 4'd7},
        '{12'h200, 32'h0000_0001, 2'd2, 4'd0, 12'h000, 4'd7},
        '{12'h001, 32'h0000_007F, 2'd1, 4'd1, 12'h07F, 4'd2},
        '{12'h080, 32'h0000_0000, 2'd2, 4'd0, 12'h000, 4'd6}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wb_cyc = 1'b0, wb_stb = 1'b0, wb_we = 1'b0;
    logic [ADR_W-1:0] wb_adr = '0;
    logic [DAT_W-1:0] wb_dat = '0;
    logic             wb_ack, wb_err, wb_rty, cmd_req;
    logic [3:0]       cmd_code;
    logic [ARG_W-1:0] cmd_arg;
    logic             cmd_accept = 1'b0;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    memcfg_wb_bridge #(.ADR_W(ADR_W), .DAT_W(DAT_W), .ARG_W(ARG_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we),
        .wb_adr(wb_adr), .wb_dat(wb_dat), .wb_ack(wb_ack), .wb_err(wb_err),
        .wb_rty(wb_rty), .cmd_req(cmd_req), .cmd_code(cmd_code), .cmd_arg(cmd_arg),
        .cmd_accept(cmd_accept)
    );

    function automatic string tag_name(input logic [3:0] t);
        case (t)
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd6: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Runs one bus cycle; accepts an offered command after 'delay' cycles.
    task automatic wb_cycle(input logic [ADR_W-1:0] adr, input logic [DAT_W-1:0] dat,
                            input bit we, input int delay,
                            output logic [1:0] resp, output bit got,
                            output logic [3:0] code, output logic [ARG_W-1:0] arg);
        int n = 0;
        resp = 2'd0; got = 1'b0; code = '0; arg = '0;
        @(negedge clk);
        wb_cyc = 1'b1; wb_stb = 1'b1; wb_we = we; wb_adr = adr; wb_dat = dat;
        while (resp == 2'd0 && n < 40) begin
            @(negedge clk); n++;
            if (wb_ack) resp = 2'd1; else if (wb_err) resp = 2'd2; else if (wb_rty) resp = 2'd3;
            cmd_accept = 1'b0;
            if (resp == 2'd0 && cmd_req && !got) begin
                got = 1'b1; code = cmd_code; arg = cmd_arg;
                for (int k = 0; k < delay; k++) begin
                    @(negedge clk);
                    chk(cmd_req && !wb_ack && cmd_code == code && cmd_arg == arg,
                        "R5 hold", {30'd0, wb_ack, cmd_req}, 32'd1);
                end
                cmd_accept = 1'b1;
            end
        end
        wb_cyc = 1'b0; wb_stb = 1'b0; wb_we = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [1:0]       resp;
        bit               got;
        logic [3:0]       code;
        logic [ARG_W-1:0] arg;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk({wb_ack, wb_err, wb_rty, cmd_req} == 4'b0, "R1 in reset",
            {28'd0, wb_ack, wb_err, wb_rty, cmd_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({wb_ack, wb_err, wb_rty, cmd_req} == 4'b0, "R1 after reset",
            {28'd0, wb_ack, wb_err, wb_rty, cmd_req}, 32'd0);

        // Table walk: R2, R3, R4, R6, R7
        for (int i = 0; i < NV; i++) begin
            wb_cycle(VECS[i].adr, VECS[i].dat, 1'b1, i % 3, resp, got, code, arg);
            chk(resp == VECS[i].resp, tag_name(VECS[i].tag), 32'(resp), 32'(VECS[i].resp));
            if (VECS[i].resp == 2'd1) begin
                chk(got && code == VECS[i].code, tag_name(VECS[i].tag), 32'(code), 32'(VECS[i].code));
                chk(arg == VECS[i].arg, tag_name(VECS[i].tag), 32'(arg), 32'(VECS[i].arg));
            end else begin
                chk(!got, tag_name(VECS[i].tag), 32'(got), 32'd0);
            end
        end

        // R7: a read cycle to a mapped address is refused
        wb_cycle(12'h001, 32'h0, 1'b0, 0, resp, got, code, arg);
        chk(resp == 2'd2 && !got, "R7 read", 32'(resp), 32'd2);

        // R9: strobe held after a termination gets no response next cycle
        @(negedge clk);
        wb_cyc = 1'b1; wb_stb = 1'b1; wb_we = 1'b1; wb_adr = 12'h000;
        @(negedge clk);
        chk(wb_err, "R9 first err", 32'(wb_err), 32'd1);
        @(negedge clk);
        chk(!(wb_ack || wb_err || wb_rty), "R9 no repeat", {29'd0, wb_ack, wb_err, wb_rty}, 32'd0);
        wb_cyc = 1'b0; wb_stb = 1'b0; wb_we = 1'b0;
        repeat (2) @(negedge clk);

        // R8 / R10: abandon a cycle, then retry, then late accept
        wb_cyc = 1'b1; wb_stb = 1'b1; wb_we = 1'b1; wb_adr = 12'h100; wb_dat = '0;
        @(negedge clk);
        chk(cmd_req && cmd_code == 4'd9, "R8 offered", 32'(cmd_code), 32'd9);
        wb_cyc = 1'b0; wb_stb = 1'b0; wb_we = 1'b0;
        repeat (2) @(negedge clk);
        wb_cycle(12'h001, 32'h5, 1'b1, 0, resp, got, code, arg);
        chk(resp == 2'd3, "R8 retry", 32'(resp), 32'd3);
        chk(cmd_req && cmd_code == 4'd9, "R8 still pending", 32'(cmd_code), 32'd9);
        cmd_accept = 1'b1;
        @(negedge clk);
        cmd_accept = 1'b0;
        chk(!wb_ack && !cmd_req, "R10 silent accept", {30'd0, wb_ack, cmd_req}, 32'd0);
        @(negedge clk);
        chk(!wb_ack, "R10 no late ack", 32'(wb_ack), 32'd0);

        // After the pending one is gone, a new write goes through (R2)
        wb_cycle(12'h001, 32'h0000_0123, 1'b1, 1, resp, got, code, arg);
        chk(resp == 2'd1 && arg == 12'h023, "R2 after retry", 32'(arg), 32'h023);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule